// File: doc/BRIEF.md
# Single-Cycle Four-Instruction Processor Datapath

This block is a 32-bit processor datapath that completes one instruction in every clock cycle. It supports a small instruction set: register addition, word load, word store and branch-if-equal. The block holds the program counter, a 32-entry register bank, a sign extender, an arithmetic unit with a zero flag, the branch-target adder and two small word-addressed memories. The instruction memory is a read-only store filled from the `PROGRAM` parameter. The data memory is loaded from the `DATA_INIT` parameter while reset is held.

The only external inputs are the clock and a synchronous reset. A debug port shows the current program counter. It also shows the contents of any register picked by a select input, so a test harness can follow execution at the ports. Any word that does not match one of the four supported encodings is executed as a no-op.

Top module: `scalar_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0, all 32 registers become 0, and data word i is loaded from bits [32*i+31:32*i] of `DATA_INIT`.
- R2: When no branch is taken, the PC advances by exactly 4 on each rising edge.
- R3: The word with op[31:26]=0x00 and funct[5:0]=0x20 writes the sum of register rs[25:21] and register rt[20:16] into register rd[15:11].
- R4: Op 0x23 (load) writes into register rt the data word at byte address rs + sext(imm[15:0]). The word index is address bits [2+:log2(DMEM_WORDS)], which wrap modulo the memory size.
- R5: Op 0x2B (store) writes register rt to the data word at rs + sext(imm[15:0]) on the rising edge. A later load from that address returns the stored value.
- R6: Op 0x04 (branch) subtracts rt from rs. When the ALU zero flag is set, the next PC is PC+4+(sext(imm)<<2); otherwise the next PC is PC+4.
- R7: The sign extender copies immediate bit 15 into bits 31:16, so 0xFFF0 acts as -16 and 0xFFFF acts as -1.
- R8: Register 0 always reads as 0, and any write aimed at it is discarded.
- R9: Any other opcode, or op 0x00 with a funct other than 0x20, changes no register and no data word, and advances the PC by 4.
- R10: `dbg_pc` shows the current PC. `dbg_reg` shows the register selected by `dbg_sel`, and it follows `dbg_sel` combinationally.
- R11: The instruction is fetched from word PC[2+:log2(IMEM_WORDS)] of `PROGRAM`, where word i occupies bits [32*i+31:32*i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dbg_sel | input | 5 | Register number to show on `dbg_reg` |
| dbg_pc | output | 32 | Current program counter |
| dbg_reg | output | 32 | Contents of the selected register |

## Verification
A wrong register, data word or PC inside the block shows up at the debug port. A bad PC appears on `dbg_pc` in the cycle after the faulty edge. A bad register value appears on `dbg_reg` as soon as that register is selected, and it also spreads into later sums, loads and branch decisions. A corrupted data word stays hidden until a load reads it back into a register. For that reason the program pairs every store with a later load, and ends in a branch loop that freezes the final state so every register can be swept.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

   localparam int unsigned XLEN = 32;

   localparam logic [5:0] OPC_SPECIAL = 6'h00;
   localparam logic [5:0] OPC_LOAD    = 6'h23;
   localparam logic [5:0] OPC_STORE   = 6'h2B;
   localparam logic [5:0] OPC_BREQ    = 6'h04;
   localparam logic [5:0] FN_SUM      = 6'h20;

   typedef struct packed {
      logic reg_we;
      logic dst_is_rd;
      logic use_imm;
      logic mem_we;
      logic load_sel;
      logic branch;
      logic alu_sub;
   } ctrl_t;

   function automatic logic [XLEN-1:0] widen_imm(input logic [15:0] imm);
      return {{(XLEN-16){imm[15]}}, imm};
   endfunction

endpackage

// File: rtl/sdp_decode.sv
module sdp_decode
   import sdp_pkg::*;
(
   input  logic [31:0] instr,
   output ctrl_t       ctrl
);
   logic [5:0] opc;
   logic [5:0] fn;
   logic       is_sum, is_load, is_store, is_breq;

   assign opc = instr[31:26];
   assign fn  = instr[5:0];

   always_comb begin
      is_sum   = (opc == OPC_SPECIAL) && (fn == FN_SUM);
      is_load  = (opc == OPC_LOAD);
      is_store = (opc == OPC_STORE);
      is_breq  = (opc == OPC_BREQ);

      ctrl           = '0;
      ctrl.reg_we    = is_sum | is_load;
      ctrl.dst_is_rd = is_sum;
      ctrl.use_imm   = is_load | is_store;
      ctrl.mem_we    = is_store;
      ctrl.load_sel  = is_load;
      ctrl.branch    = is_breq;
      ctrl.alu_sub   = is_breq;
   end

   // R3, R4, R5, R6, R9: at most one instruction class decodes at a time
   always_comb begin
      assert_one_class_R9: assert ($onehot0({is_sum, is_load, is_store, is_breq}))
         else $error("decode matched more than one class");
   end

endmodule

// File: rtl/sdp_alu.sv
module sdp_alu #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             sub,
   output logic [WIDTH-1:0] result,
   output logic             zero
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sdp_alu: WIDTH must be at least 2");
      end
   endgenerate

   always_comb begin
      result = sub ? (op_a - op_b) : (op_a + op_b);
      zero   = (result == '0);
   end
endmodule

// File: rtl/sdp_regbank.sv
module sdp_regbank #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned NREG  = 32,
   parameter int unsigned NRD   = 3,
   localparam int unsigned AW   = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [AW-1:0]    raddr [NRD],
   output logic [WIDTH-1:0] rdata [NRD],
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata
);
   generate
      if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
         $error("sdp_regbank: NREG must be a power of two of at least 2");
      end
      if (NRD < 1) begin : g_bad_nrd
         $error("sdp_regbank: at least one read port is needed");
      end
   endgenerate

   logic [WIDTH-1:0] cells [NREG];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREG; i++) cells[i] <= '0;
      end else if (we && waddr != '0) begin
         cells[waddr] <= wdata;
      end
   end

   genvar p;
   generate
      for (p = 0; p < NRD; p++) begin : g_rd
         assign rdata[p] = (raddr[p] == '0) ? '0 : cells[raddr[p]];
      end
   endgenerate

   // R8: any write aimed at entry 0 is discarded
   assert_zero_entry_R8: assert property (@(posedge clk) disable iff (rst)
      (we && waddr == '0) |=> (cells[0] == '0));

   // R3, R4: a write to a nonzero entry lands in that entry
   assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
      (we && waddr != '0) |=> (cells[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/scalar_datapath.sv
module scalar_datapath
   import sdp_pkg::*;
#(
   parameter int unsigned IMEM_WORDS = 16,
   parameter int unsigned DMEM_WORDS = 16,
   parameter logic [32*IMEM_WORDS-1:0] PROGRAM   = '0,
   parameter logic [32*DMEM_WORDS-1:0] DATA_INIT = '0
) (
   input  logic        clk,
   input  logic        rst,
   input  logic [4:0]  dbg_sel,
   output logic [31:0] dbg_pc,
   output logic [31:0] dbg_reg
);
   localparam int unsigned IA_W = $clog2(IMEM_WORDS);
   localparam int unsigned DA_W = $clog2(DMEM_WORDS);

   generate
      if (IMEM_WORDS < 2 || (IMEM_WORDS & (IMEM_WORDS - 1)) != 0) begin : g_bad_imem
         $error("scalar_datapath: IMEM_WORDS must be a power of two of at least 2");
      end
      if (DMEM_WORDS < 2 || (DMEM_WORDS & (DMEM_WORDS - 1)) != 0) begin : g_bad_dmem
         $error("scalar_datapath: DMEM_WORDS must be a power of two of at least 2");
      end
      if (IA_W + 2 > XLEN || DA_W + 2 > XLEN) begin : g_bad_span
         $error("scalar_datapath: memory larger than the address space");
      end
   endgenerate

   logic [XLEN-1:0] pc_q, pc_next, pc_inc, pc_target;
   logic [31:0]     instr;
   ctrl_t           ctrl;
   logic [4:0]      f_rs, f_rt, f_rd, w_addr;
   logic [XLEN-1:0] rs_val, rt_val, imm_x, alu_b, alu_y, ld_word, w_data;
   logic            alu_zero, taken;
   logic [DA_W-1:0] d_idx;
   logic [4:0]      rb_raddr [3];
   logic [XLEN-1:0] rb_rdata [3];
   logic [XLEN-1:0] dmem [DMEM_WORDS];
   logic            unused_bits;

   // fetch
   assign instr = PROGRAM[32*pc_q[2 +: IA_W] +: 32];
   assign f_rs  = instr[25:21];
   assign f_rt  = instr[20:16];
   assign f_rd  = instr[15:11];
   assign imm_x = widen_imm(instr[15:0]);

   sdp_decode u_dec (
      .instr (instr),
      .ctrl  (ctrl)
   );

   assign rb_raddr[0] = f_rs;
   assign rb_raddr[1] = f_rt;
   assign rb_raddr[2] = dbg_sel;
   assign rs_val      = rb_rdata[0];
   assign rt_val      = rb_rdata[1];
   assign dbg_reg     = rb_rdata[2];

   sdp_regbank #(
      .WIDTH (XLEN),
      .NREG  (32),
      .NRD   (3)
   ) u_regs (
      .clk   (clk),
      .rst   (rst),
      .raddr (rb_raddr),
      .rdata (rb_rdata),
      .we    (ctrl.reg_we),
      .waddr (w_addr),
      .wdata (w_data)
   );

   assign alu_b = ctrl.use_imm ? imm_x : rt_val;

   sdp_alu #(.WIDTH(XLEN)) u_alu (
      .op_a   (rs_val),
      .op_b   (alu_b),
      .sub    (ctrl.alu_sub),
      .result (alu_y),
      .zero   (alu_zero)
   );

   // data memory
   assign d_idx   = alu_y[2 +: DA_W];
   assign ld_word = dmem[d_idx];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DMEM_WORDS; i++) dmem[i] <= DATA_INIT[32*i +: 32];
      end else if (ctrl.mem_we) begin
         dmem[d_idx] <= rt_val;
      end
   end

   // write-back
   assign w_addr = ctrl.dst_is_rd ? f_rd : f_rt;
   assign w_data = ctrl.load_sel ? ld_word : alu_y;

   // next PC
   assign pc_inc    = pc_q + XLEN'(4);
   assign pc_target = pc_inc + (imm_x << 2);
   assign taken     = ctrl.branch & alu_zero;
   assign pc_next   = taken ? pc_target : pc_inc;

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_next;
   end

   assign dbg_pc = pc_q;

   assign unused_bits = ^{instr[10:6], alu_y[1:0], pc_q[1:0]};

   // R2: without a taken branch the PC steps by four
   assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
      !taken |=> (dbg_pc == $past(dbg_pc) + 32'd4));

   // R6: a taken branch lands on PC+4 plus the scaled offset
   assert_branch_dest_R6: assert property (@(posedge clk) disable iff (rst)
      taken |=> (dbg_pc == $past(dbg_pc) + 32'd4 + ($past(imm_x) << 2)));

   // R6: the zero flag only fires for equal operands
   assert_branch_equal_R6: assert property (@(posedge clk) disable iff (rst)
      taken |-> (rs_val == rt_val));

   // R5, R9: a store never writes a register in the same cycle
   assert_store_no_wb_R5: assert property (@(posedge clk) disable iff (rst)
      ctrl.mem_we |-> !ctrl.reg_we);

   // R1: the cycle after reset starts at address zero
   assert_reset_pc_R1: assert property (@(posedge clk)
      rst |=> (dbg_pc == 32'd0));

endmodule

// File: tb/scalar_datapath_test.sv
module scalar_datapath_test;

   localparam int NW = 16;

   // program: word index -> encoding
   localparam logic [31:0] P0  = 32'h8C010000; // lw  $1, 0($0)
   localparam logic [31:0] P1  = 32'h8C020004; // lw  $2, 4($0)
   localparam logic [31:0] P2  = 32'h00221820; // add $3, $1, $2
   localparam logic [31:0] P3  = 32'hAC030010; // sw  $3, 16($0)
   localparam logic [31:0] P4  = 32'h8C040010; // lw  $4, 16($0)
   localparam logic [31:0] P5  = 32'h00220020; // add $0, $1, $2 (discarded)
   localparam logic [31:0] P6  = 32'h10640001; // beq $3, $4, +1 (taken)
   localparam logic [31:0] P7  = 32'h00212820; // add $5, $1, $1 (skipped)
   localparam logic [31:0] P8  = 32'h8C67FFF8; // lw  $7, -8($3)
   localparam logic [31:0] P9  = 32'h10220005; // beq $1, $2, +5 (not taken)
   localparam logic [31:0] P10 = 32'h3C010005; // unsupported opcode
   localparam logic [31:0] P11 = 32'h00224022; // op 0 with funct 0x22
   localparam logic [31:0] P12 = 32'h8C060008; // lw  $6, 8($0)
   localparam logic [31:0] P13 = 32'h00C14820; // add $9, $6, $1
   localparam logic [31:0] P14 = 32'h1000FFFF; // beq $0, $0, -1 (self loop)
   localparam logic [31:0] P15 = 32'h00000000;

   localparam logic [32*NW-1:0] PROG = {P15, P14, P13, P12, P11, P10, P9, P8,
                                        P7, P6, P5, P4, P3, P2, P1, P0};
   localparam logic [32*NW-1:0] DINIT = {{12{32'h0}}, 32'h12345678,
                                         32'hFFFFFFF0, 32'd7, 32'd5};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  dbg_sel = '0;
   logic [31:0] dbg_pc, dbg_reg;

   always #2 clk = ~clk;

   scalar_datapath #(
      .IMEM_WORDS (NW),
      .DMEM_WORDS (NW),
      .PROGRAM    (PROG),
      .DATA_INIT  (DINIT)
   ) uut (
      .clk     (clk),
      .rst     (rst),
      .dbg_sel (dbg_sel),
      .dbg_pc  (dbg_pc),
      .dbg_reg (dbg_reg)
   );

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   // reference machine state
   logic [31:0] m_pc;
   logic [31:0] m_reg [32];
   logic [31:0] m_mem [NW];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_pc = 0;
      for (int i = 0; i < 32; i++) m_reg[i] = 0;
      for (int i = 0; i < NW; i++) m_mem[i] = DINIT[32*i +: 32];
   endtask

   task automatic model_step();
      logic [31:0] w, a, b, off, ea, npc;
      logic [5:0]  op, fn;
      int          s, t, d;
      w   = PROG[32*((m_pc >> 2) % NW) +: 32];
      op  = w[31:26];
      fn  = w[5:0];
      s   = w[25:21];
      t   = w[20:16];
      d   = w[15:11];
      a   = m_reg[s];
      b   = m_reg[t];
      off = {{16{w[15]}}, w[15:0]};
      ea  = a + off;
      npc = m_pc + 4;
      if (op == 6'h00 && fn == 6'h20) begin
         if (d != 0) m_reg[d] = a + b;
      end else if (op == 6'h23) begin
         if (t != 0) m_reg[t] = m_mem[(ea >> 2) % NW];
      end else if (op == 6'h2B) begin
         m_mem[(ea >> 2) % NW] = b;
      end else if (op == 6'h04) begin
         if (a == b) npc = m_pc + 4 + (off << 2);
      end
      m_pc = npc;
   endtask

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset pc", dbg_pc, 32'd0);
      for (int i = 0; i < 32; i++) begin
         dbg_sel = 5'(i);
         #0.5;
         check("R1 reset register", dbg_reg, 32'd0);
      end
      rst = 1'b0;
      for (int c = 0; c < 60; c++) begin
         @(posedge clk);
         model_step();
         @(negedge clk);
         check("R2 R6 R11 pc vs model", dbg_pc, m_pc);
         dbg_sel = 5'(c % 32);
         #0.5;
         check("R3 R4 R10 register vs model", dbg_reg, m_reg[c % 32]);
      end
      // frozen state: sweep every register against the model
      for (int i = 0; i < 32; i++) begin
         dbg_sel = 5'(i);
         #0.5;
         check("R10 final sweep", dbg_reg, m_reg[i]);
      end
      // explicit values worked out from the requirements
      dbg_sel = 5'd1; #0.5; check("R4 load word 0", dbg_reg, 32'd5);
      dbg_sel = 5'd3; #0.5; check("R3 sum", dbg_reg, 32'd12);
      dbg_sel = 5'd4; #0.5; check("R5 store then load", dbg_reg, 32'd12);
      dbg_sel = 5'd0; #0.5; check("R8 zero register", dbg_reg, 32'd0);
      dbg_sel = 5'd5; #0.5; check("R6 skipped by taken branch", dbg_reg, 32'd0);
      dbg_sel = 5'd7; #0.5; check("R7 negative offset load", dbg_reg, 32'd7);
      dbg_sel = 5'd8; #0.5; check("R9 unsupported funct", dbg_reg, 32'd0);
      dbg_sel = 5'd6; #0.5; check("R7 negative data", dbg_reg, 32'hFFFFFFF0);
      dbg_sel = 5'd9; #0.5; check("R3 signed sum", dbg_reg, 32'hFFFFFFF5);
      check("R6 self loop pc", dbg_pc, 32'd56);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule